// File: doc/BRIEF.md
# Peripheral Security Access Gate

The gate sits between one upstream requester and up to sixteen downstream peripheral ports. Each request names a target port and carries an address, write data, a byte size, a write flag and two attributes: secure and user (unprivileged). Before anything reaches a peripheral, the gate checks those attributes against that port's configuration. It decides whether the port lives in the secure or the non-secure world, and whether unprivileged code may touch it.

A permitted request is handed unchanged to the chosen port, and the port's response (data plus OK or error) goes back upstream. A forbidden request never reaches any port. It is answered one cycle after acceptance, either with an error or silently: reads return zero and writes are dropped, both with an OK status. The choice is set by a configuration input. Each forbidden request also sets a sticky violation flag, which drives an interrupt through an enable input and is cleared by a clear input. A compile-time mask can exempt chosen ports from the security-world check. The mask never exempts a port from the privilege check.

Top module: `sec_gate`

## Requirements
- R1: A request to port n is refused when `up_secure` equals bit n of `cfg_nonsec` and bit n of parameter `SEC_BYPASS` is 0. Bit n set in `cfg_nonsec` means port n is non-secure; bit 0 belongs to port 0.
- R2: When bit n of `SEC_BYPASS` is 1, the secure attribute has no effect on whether a request to port n is refused.
- R3: A request with `up_user`=1 to port n is refused when bit n of `cfg_user_ok` is 0, whatever `SEC_BYPASS` holds.
- R4: A refused request completes with `up_rsp_err` equal to `cfg_err_resp` sampled at acceptance. When that value is 0, `up_rdata` is zero.
- R5: A refused request never raises any `dn_valid` bit, and `up_rsp_valid` is high in the cycle after acceptance.
- R6: A permitted request raises only `dn_valid[up_port]`, with address, data, size, write flag and attributes unchanged, and holds it until `dn_ready` of that port. The port's `dn_rsp_err` and its `DW`-bit slice of `dn_rdata` are returned in `up_rsp_err` and `up_rdata`.
- R7: A refused request sets the violation flag at its acceptance edge unless `irq_clr` is high at that edge. The flag stays set through later permitted requests.
- R8: While `irq_clr` is high at a clock edge, the flag is 0 after that edge.
- R9: `irq` is the AND of the flag and `irq_en`, and follows `irq_en` with no clock delay.
- R10: Only one request is in flight: `up_ready` is low from acceptance until the response handshake. The response is held stable while `up_rsp_ready` is low.
- R11: After reset, `up_ready` is 1 and `irq`, `up_rsp_valid` and every `dn_valid` bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_nonsec | input | NPORTS | Per-port world: 1 non-secure, 0 secure |
| cfg_user_ok | input | NPORTS | Per-port unprivileged access permitted |
| cfg_err_resp | input | 1 | Refusal answer: 1 error, 0 silent |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Violation flag clear and suppress |
| irq | output | 1 | Violation interrupt |
| up_valid | input | 1 | Request valid |
| up_ready | output | 1 | Gate can accept a request |
| up_port | input | PW | Target port index |
| up_addr | input | AW | Request address |
| up_wdata | input | DW | Write data |
| up_size | input | 2 | Log2 of byte count (0..3 for 1..8 bytes) |
| up_write | input | 1 | 1 write, 0 read |
| up_secure | input | 1 | Secure attribute |
| up_user | input | 1 | Unprivileged attribute |
| up_rsp_valid | output | 1 | Response valid |
| up_rsp_ready | input | 1 | Response taken |
| up_rsp_err | output | 1 | Response error status |
| up_rdata | output | DW | Read data |
| dn_valid | output | NPORTS | Per-port request valid |
| dn_ready | input | NPORTS | Per-port request accepted |
| dn_addr | output | AW | Forwarded address |
| dn_wdata | output | DW | Forwarded write data |
| dn_size | output | 2 | Forwarded size |
| dn_write | output | 1 | Forwarded write flag |
| dn_secure | output | 1 | Forwarded secure attribute |
| dn_user | output | 1 | Forwarded user attribute |
| dn_rsp_valid | input | NPORTS | Per-port response valid |
| dn_rsp_ready | output | NPORTS | Per-port response taken |
| dn_rsp_err | input | NPORTS | Per-port response error |
| dn_rdata | input | NPORTS*DW | Per-port read data, port n at bits n*DW upward |

## Verification
The bench drives four attribute patterns against ports of each world: secure privileged, non-secure privileged, secure user and non-secure user. These separate the world check from the privilege check. A port listed in the bypass mask is hit with a mismatched world and then with a user request, which shows the mask lifts only the world check. Refused reads and writes run under both answer modes, and the bench confirms that no downstream valid appears. Interrupt patterns toggle the enable with no clock, pulse the clear, and hold the clear across a refusal to tell a clear apart from a suppression.

// File: rtl/sec_gate.sv
module sec_gate #(
  parameter int NPORTS = 16,
  parameter int AW = 32,
  parameter int DW = 64,
  parameter logic [NPORTS-1:0] SEC_BYPASS = '0,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    cfg_nonsec,
  input  logic [NPORTS-1:0]    cfg_user_ok,
  input  logic                 cfg_err_resp,
  input  logic                 irq_en,
  input  logic                 irq_clr,
  output logic                 irq,
  input  logic                 up_valid,
  output logic                 up_ready,
  input  logic [PW-1:0]        up_port,
  input  logic [AW-1:0]        up_addr,
  input  logic [DW-1:0]        up_wdata,
  input  logic [1:0]           up_size,
  input  logic                 up_write,
  input  logic                 up_secure,
  input  logic                 up_user,
  output logic                 up_rsp_valid,
  input  logic                 up_rsp_ready,
  output logic                 up_rsp_err,
  output logic [DW-1:0]        up_rdata,
  output logic [NPORTS-1:0]    dn_valid,
  input  logic [NPORTS-1:0]    dn_ready,
  output logic [AW-1:0]        dn_addr,
  output logic [DW-1:0]        dn_wdata,
  output logic [1:0]           dn_size,
  output logic                 dn_write,
  output logic                 dn_secure,
  output logic                 dn_user,
  input  logic [NPORTS-1:0]    dn_rsp_valid,
  output logic [NPORTS-1:0]    dn_rsp_ready,
  input  logic [NPORTS-1:0]    dn_rsp_err,
  input  logic [NPORTS*DW-1:0] dn_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_FWD, S_WAIT, S_RESP} state_t;

  state_t          state;
  logic [PW-1:0]   port_q;
  logic            flag;
  logic            accept, world_bad, priv_bad, deny;
  logic [NPORTS-1:0] sel;

  assign up_ready  = (state == S_IDLE);
  assign accept    = up_valid & up_ready;
  assign world_bad = (up_secure == cfg_nonsec[up_port]) & ~SEC_BYPASS[up_port];
  assign priv_bad  = up_user & ~cfg_user_ok[up_port];
  assign deny      = world_bad | priv_bad;

  assign sel          = NPORTS'(1) << port_q;
  assign dn_valid     = (state == S_FWD)  ? sel : '0;
  assign dn_rsp_ready = (state == S_WAIT) ? sel : '0;
  assign up_rsp_valid = (state == S_RESP);
  assign irq          = flag & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      port_q      <= '0;
      dn_addr     <= '0;
      dn_wdata    <= '0;
      dn_size     <= '0;
      dn_write    <= 1'b0;
      dn_secure   <= 1'b0;
      dn_user     <= 1'b0;
      up_rsp_err  <= 1'b0;
      up_rdata    <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          port_q    <= up_port;
          dn_addr   <= up_addr;
          dn_wdata  <= up_wdata;
          dn_size   <= up_size;
          dn_write  <= up_write;
          dn_secure <= up_secure;
          dn_user   <= up_user;
          if (deny) begin
            up_rsp_err <= cfg_err_resp;
            up_rdata   <= '0;
            state      <= S_RESP;
          end else begin
            state <= S_FWD;
          end
        end
        S_FWD: if (dn_ready[port_q]) state <= S_WAIT;
        S_WAIT: if (dn_rsp_valid[port_q]) begin
          up_rsp_err <= dn_rsp_err[port_q];
          up_rdata   <= dn_rdata[port_q*DW +: DW];
          state      <= S_RESP;
        end
        S_RESP: if (up_rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              flag <= 1'b0;
    else if (irq_clr)        flag <= 1'b0;
    else if (accept && deny) flag <= 1'b1;
  end

endmodule

// File: rtl/sec_gate_chk.sv
module sec_gate_chk #(
  parameter int NP = 16,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          up_ready,
  input logic          up_rsp_valid,
  input logic          up_rsp_ready,
  input logic          up_rsp_err,
  input logic [DW-1:0] up_rdata,
  input logic [NP-1:0] dn_valid,
  input logic [NP-1:0] dn_ready,
  input logic          irq,
  input logic          irq_en,
  input logic          irq_clr
);

  a_r6_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_valid));

  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|dn_valid && !(|(dn_valid & dn_ready))) |=> (dn_valid == $past(dn_valid)));

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && !up_rsp_ready) |=> (up_rsp_valid && $stable(up_rsp_err) && $stable(up_rdata)));

  a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid |-> !up_ready);

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq);

endmodule

bind sec_gate sec_gate_chk #(.NP(NPORTS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_ready(up_ready), .up_rsp_valid(up_rsp_valid),
  .up_rsp_ready(up_rsp_ready), .up_rsp_err(up_rsp_err), .up_rdata(up_rdata),
  .dn_valid(dn_valid), .dn_ready(dn_ready), .irq(irq), .irq_en(irq_en),
  .irq_clr(irq_clr)
);

// File: tb/tb_sec_gate.sv
module tb_sec_gate;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int PW = 4;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] cfg_nonsec = '0, cfg_user_ok = '0;
  logic cfg_err_resp = 0, irq_en = 0, irq_clr = 0, irq;
  logic up_valid = 0, up_ready;
  logic [PW-1:0] up_port = '0;
  logic [AW-1:0] up_addr = '0;
  logic [DW-1:0] up_wdata = '0;
  logic [1:0] up_size = '0;
  logic up_write = 0, up_secure = 0, up_user = 0;
  logic up_rsp_valid, up_rsp_ready = 0, up_rsp_err;
  logic [DW-1:0] up_rdata;
  logic [NP-1:0] dn_valid, dn_ready, dn_rsp_valid = '0, dn_rsp_ready, dn_rsp_err = '0;
  logic [AW-1:0] dn_addr;
  logic [DW-1:0] dn_wdata;
  logic [1:0] dn_size;
  logic dn_write, dn_secure, dn_user;
  logic [NP*DW-1:0] dn_rdata = '0;

  int total = 0, bad = 0;
  bit done = 0;

  assign dn_ready = '1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_gate #(.NPORTS(NP), .AW(AW), .DW(DW), .SEC_BYPASS(16'h0100)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_nonsec(cfg_nonsec), .cfg_user_ok(cfg_user_ok),
    .cfg_err_resp(cfg_err_resp), .irq_en(irq_en), .irq_clr(irq_clr), .irq(irq),
    .up_valid(up_valid), .up_ready(up_ready), .up_port(up_port), .up_addr(up_addr),
    .up_wdata(up_wdata), .up_size(up_size), .up_write(up_write), .up_secure(up_secure),
    .up_user(up_user), .up_rsp_valid(up_rsp_valid), .up_rsp_ready(up_rsp_ready),
    .up_rsp_err(up_rsp_err), .up_rdata(up_rdata), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_size(dn_size), .dn_write(dn_write),
    .dn_secure(dn_secure), .dn_user(dn_user), .dn_rsp_valid(dn_rsp_valid),
    .dn_rsp_ready(dn_rsp_ready), .dn_rsp_err(dn_rsp_err), .dn_rdata(dn_rdata)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_rsp();
    up_rsp_ready = 1;
    @(negedge clk);
    up_rsp_ready = 0;
  endtask

  task automatic issue(input int port, input logic sec, input logic usr,
                       input logic wr, input logic [DW-1:0] wd);
    @(negedge clk);
    up_port = PW'(port); up_secure = sec; up_user = usr; up_write = wr;
    up_wdata = wd; up_addr = 32'h4000_0000 + 32'(port * 16); up_size = 2'd3;
    up_valid = 1;
    @(negedge clk);
    up_valid = 0;
  endtask

  task automatic expect_refused(input string tag, input logic err);
    chk({tag, " R5 rsp next cycle"}, 64'(up_rsp_valid), 64'd1);
    chk({tag, " R5 no downstream"}, 64'(dn_valid), 64'd0);
    chk({tag, " R4 err"}, 64'(up_rsp_err), 64'(err));
    if (!err) chk({tag, " R4 zero data"}, up_rdata, 64'd0);
    @(negedge clk);
    chk({tag, " R10 held"}, 64'({up_rsp_valid, up_ready}), 64'b10);
    chk({tag, " R5 still no downstream"}, 64'(dn_valid), 64'd0);
    finish_rsp();
  endtask

  task automatic expect_fwd(input string tag, input int port, input logic derr,
                            input logic [DW-1:0] dd);
    chk({tag, " R6 valid onehot"}, 64'(dn_valid), 64'(NP'(1) << port));
    chk({tag, " R6 fields"}, 64'({dn_addr, dn_size, dn_write, dn_secure, dn_user}),
        64'({up_addr, up_size, up_write, up_secure, up_user}));
    chk({tag, " R6 wdata"}, dn_wdata, up_wdata);
    chk({tag, " R10 busy"}, 64'(up_ready), 64'd0);
    @(negedge clk);
    dn_rsp_valid = '1; dn_rsp_err = derr ? '1 : '0;
    dn_rdata = '0; dn_rdata[port*DW +: DW] = dd;
    @(negedge clk);
    dn_rsp_valid = '0;
    chk({tag, " R6 rsp valid"}, 64'(up_rsp_valid), 64'd1);
    chk({tag, " R6 rsp err"}, 64'(up_rsp_err), 64'(derr));
    chk({tag, " R6 rsp data"}, up_rdata, dd);
    finish_rsp();
  endtask

  task automatic t_reset();
    #1;
    chk("R11 ready", 64'(up_ready), 64'd1);
    chk("R11 irq", 64'(irq), 64'd0);
    chk("R11 rsp", 64'(up_rsp_valid), 64'd0);
    chk("R11 dn", 64'(dn_valid), 64'd0);
  endtask

  task automatic t_permitted();
    issue(0, 1, 0, 0, 64'h0);
    expect_fwd("sec port secure access", 0, 0, 64'h1122_3344_5566_7788);
    issue(4, 0, 1, 1, 64'hdead_beef_0bad_f00d);
    expect_fwd("nonsec port user write", 4, 1, 64'h55);
  endtask

  task automatic t_world();
    cfg_err_resp = 1;
    issue(0, 0, 0, 0, 64'h0);
    expect_refused("R1 nonsec to secure port", 1);
    cfg_err_resp = 0;
    issue(5, 1, 0, 0, 64'h0);
    expect_refused("R1 secure to nonsec port read", 0);
    issue(5, 1, 0, 1, 64'hffff);
    expect_refused("R1 secure to nonsec port write", 0);
  endtask

  task automatic t_bypass();
    issue(8, 0, 0, 0, 64'h0);
    expect_fwd("R2 masked port mismatched world", 8, 0, 64'habcd);
    issue(8, 1, 0, 0, 64'h0);
    expect_fwd("R2 masked port secure", 8, 0, 64'h1234);
  endtask

  task automatic t_user();
    cfg_err_resp = 1;
    issue(8, 0, 1, 0, 64'h0);
    expect_refused("R3 masked port user", 1);
    issue(1, 1, 1, 0, 64'h0);
    expect_refused("R3 secure port user", 1);
  endtask

  task automatic t_irq();
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    irq_en = 1; #1;
    chk("R8 cleared", 64'(irq), 64'd0);
    irq_en = 0;
    issue(0, 0, 0, 0, 64'h0);
    #1 chk("R9 disabled", 64'(irq), 64'd0);
    irq_en = 1; #1;
    chk("R9 follows enable R7 set", 64'(irq), 64'd1);
    irq_en = 0; #1;
    chk("R9 drops with enable", 64'(irq), 64'd0);
    irq_en = 1;
    finish_rsp();
    issue(0, 1, 0, 0, 64'h0);
    expect_fwd("R7 sticky permitted", 0, 0, 64'h9);
    chk("R7 sticky", 64'(irq), 64'd1);
    irq_clr = 1; @(negedge clk);
    chk("R8 clear", 64'(irq), 64'd0);
    @(negedge clk);
    up_port = 4'd0; up_secure = 0; up_user = 0; up_write = 0; up_valid = 1;
    @(negedge clk);
    up_valid = 0; irq_clr = 0; #1;
    chk("R7 suppressed by clear", 64'(irq), 64'd0);
    finish_rsp();
    @(negedge clk);
    chk("R7 still suppressed", 64'(irq), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    cfg_nonsec = 16'h00F0;
    cfg_user_ok = 16'h0011;
    @(negedge clk);
    t_permitted();
    t_world();
    t_bypass();
    t_user();
    t_irq();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule